// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side buffer bookkeeping of an Ethernet MAC. It keeps a ring of two-word descriptors in a small internal memory that stands in for system RAM. Each descriptor has two words. The first word carries a buffer address together with an ownership flag and a wrap flag. The second word records the status of a completed frame. The block does not move payload bytes to memory. It only counts the bytes of each incoming frame and tags the descriptor when the frame ends.

Frames arrive as a stream of beats with start and end markers. An address-class vector is presented with the final beat. When a frame starts, the block claims the current descriptor if hardware owns it. When the frame ends, the block writes the length and class flags, passes ownership to software and moves to the next entry. Software prepares descriptors and returns them through a word-addressed register port. It loads the first ring entry while reception is disabled. Toggling the receive enable rewinds the ring to that entry. Three sticky status bits report received frames, dropped frames and the lack of a free buffer.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the three status bits read 0, `cur_idx` is 0, and every descriptor's word 0 reads back with bit 1 (wrap) and bit 0 (ownership) both 0, meaning hardware-owned.
- R2: A frame that ends on a claimed descriptor writes word 1 as follows. Bits [10:0] hold the length. Bits [22:11] are 0. Bits [31:23] hold `rx_class[8:0]`, where bit 8 is broadcast, bit 7 is multicast hash match, bit 6 is unicast hash match, bit 5 is external match, bit 4 is unknown source and bits 3..0 are specific-address matches 4..1. The same frame sets bit 0 of that descriptor's word 0.
- R3: The length counts every valid beat from the start beat through the end beat inclusive. A one-beat frame (start and end together) has length 1. The length saturates at `BUF_BYTES`, which defaults to 1536.
- R4: After a completed frame, `cur_idx` moves to the ring base if the descriptor's wrap bit was set. Otherwise it moves to the next entry, and the entry after `DEPTH-1` is 0.
- R5: A software write to word 0 (`sw_addr` bit 0 = 0, bits above it = entry) stores bits [31:2] as the address, bit 1 as wrap and bit 0 as ownership. A read presents the word on `sw_rdata` one clock after `sw_rd`.
- R6: Software writes to word 1 (`sw_addr` bit 0 = 1) have no effect on the stored word.
- R7: A frame that starts while the current descriptor is software-owned is dropped. `cur_idx` and the descriptor stay unchanged, and both `st_ovr` and `st_bna` are set.
- R8: The status bits are sticky and are cleared by writing a one to `st_clr` (bit 0 received, bit 1 overrun, bit 2 buffer-not-available). A set and a clear of the same bit in one cycle leave the bit set.
- R9: While `rx_en` is 0, frame beats are ignored and `cur_idx` is held at the ring base, so re-enabling starts at the base. Dropping `rx_en` in the middle of a frame discards that frame without writing a descriptor.
- R10: `qptr_wr` loads `qptr_idx` as the ring base and as `cur_idx` only while `rx_en` is 0. While enabled it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| rx_valid | input | 1 | One frame byte present this cycle |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_class | input | 9 | Address-match flags, valid with the last beat |
| sw_wr | input | 1 | Software descriptor word write |
| sw_rd | input | 1 | Software descriptor word read |
| sw_addr | input | IW+1 | {entry, word select} |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Registered read data |
| qptr_wr | input | 1 | Load ring base |
| qptr_idx | input | IW | Ring base entry |
| st_clr | input | 3 | Write-one-to-clear for the status bits |
| st_rec | output | 1 | Frame received |
| st_ovr | output | 1 | Frame dropped |
| st_bna | output | 1 | No free descriptor at frame start |
| cur_idx | output | IW | Current ring entry |

## Verification
Two cases can land in one clock edge. In the first, the final beat of a frame sets the received bit while software writes a one to clear it. The bench drives `st_clr` bit 0 on the end beat of a frame and expects `st_rec` to read 1 afterwards. A second clear-only pulse must then bring it to 0. In the second case, the hardware's ownership hand-off races a software word 0 write. The design resolves this in favour of hardware, and an assertion in the descriptor store covers the hand-off.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int CLS_W = 9;
  localparam int LEN_W = 11;
  localparam int PAD_W = 32 - CLS_W - LEN_W;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_RECV,
    WK_DROP
  } walk_st_t;
endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic [IW:0]   sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic          hw_wr,
  input  logic [IW-1:0] hw_idx,
  input  logic [31:0]   hw_word1,
  input  logic [IW-1:0] look_idx,
  output logic          look_own,
  output logic          look_wrap
);
  logic [29:0]      addr_ram [DEPTH];
  logic [31:0]      stat_ram [DEPTH];
  logic [DEPTH-1:0] own_q;
  logic [DEPTH-1:0] wrap_q;
  logic [IW-1:0]    sw_ent;
  logic             sw_w1;

  assign sw_ent = sw_addr[IW:1];
  assign sw_w1  = sw_addr[0];

  // address words: software is the only writer
  always_ff @(posedge clk) begin
    if (sw_wr && !sw_w1) addr_ram[sw_ent] <= sw_wdata[31:2];
  end

  // status words: hardware is the only writer
  always_ff @(posedge clk) begin
    if (hw_wr) stat_ram[hw_idx] <= hw_word1;
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) begin
          own_q[e]  <= 1'b0;
          wrap_q[e] <= 1'b0;
        end else begin
          if (sw_wr && !sw_w1 && sw_ent == IW'(e)) begin
            own_q[e]  <= sw_wdata[0];
            wrap_q[e] <= sw_wdata[1];
          end
          if (hw_wr && hw_idx == IW'(e)) own_q[e] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (sw_rd)
      sw_rdata <= sw_w1 ? stat_ram[sw_ent]
                        : {addr_ram[sw_ent], wrap_q[sw_ent], own_q[sw_ent]};
  end

  assign look_own  = own_q[look_idx];
  assign look_wrap = wrap_q[look_idx];

  AST_HANDOFF_OWN: assert property (@(posedge clk) disable iff (rst)
    hw_wr |=> own_q[$past(hw_idx)]);  // R2
endmodule

// File: rtl/rxr_ring_walk.sv
module rxr_ring_walk
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BUF_BYTES = 1536,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [CLS_W-1:0] rx_class,
  input  logic             qptr_wr,
  input  logic [IW-1:0]    qptr_idx,
  input  logic             cur_own,
  input  logic             cur_wrap,
  output logic [IW-1:0]    idx,
  output logic             hw_wr,
  output logic [31:0]      hw_word1,
  output logic             ev_rec,
  output logic             ev_drop
);
  localparam logic [LEN_W-1:0] CAP  = LEN_W'(BUF_BYTES);
  localparam logic [IW-1:0]    LAST = IW'(DEPTH - 1);

  walk_st_t         st;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_next;
  logic [IW-1:0]    base;
  logic [IW-1:0]    nxt_idx;
  logic beat, start, claim, refuse, cont, finish;

  always_comb begin
    beat     = rx_en && rx_valid;
    start    = beat && rx_sof;
    claim    = start && !cur_own;
    refuse   = start && cur_own;
    cont     = beat && !rx_sof && (st == WK_RECV);
    finish   = (claim || cont) && rx_eof;
    len_next = start ? LEN_W'(1) : ((cnt == CAP) ? CAP : cnt + LEN_W'(1));
    nxt_idx  = cur_wrap ? base : ((idx == LAST) ? '0 : idx + IW'(1));
  end

  assign hw_wr    = finish;
  assign hw_word1 = {rx_class, {PAD_W{1'b0}}, len_next};
  assign ev_rec   = finish;
  assign ev_drop  = refuse;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= WK_IDLE;
      idx  <= '0;
      base <= '0;
      cnt  <= '0;
    end else if (!rx_en) begin
      st <= WK_IDLE;
      if (qptr_wr) begin
        base <= qptr_idx;
        idx  <= qptr_idx;
      end else begin
        idx <= base;
      end
    end else begin
      if (claim || cont) cnt <= len_next;
      if (finish) begin
        st  <= WK_IDLE;
        idx <= nxt_idx;
      end else if (claim) begin
        st <= WK_RECV;
      end else if (refuse) begin
        st <= rx_eof ? WK_IDLE : WK_DROP;
      end else if (st == WK_DROP && beat && rx_eof) begin
        st <= WK_IDLE;
      end
    end
  end

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    hw_wr |-> (hw_word1[LEN_W-1:0] != '0 && hw_word1[LEN_W-1:0] <= CAP));  // R3
  AST_IDLE_AT_BASE: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !qptr_wr) |=> idx == $past(base));  // R9
  AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> base == $past(base));  // R10
  AST_DROP_HOLDS_IDX: assert property (@(posedge clk) disable iff (rst)
    ev_drop |=> idx == $past(idx));  // R7
  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
    (hw_wr && cur_wrap) |=> idx == $past(base));  // R4
endmodule

// File: rtl/rxr_status.sv
module rxr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_rec,
  input  logic       set_drop,
  input  logic [2:0] clr,
  output logic       st_rec,
  output logic       st_ovr,
  output logic       st_bna
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_rec <= 1'b0;
      st_ovr <= 1'b0;
      st_bna <= 1'b0;
    end else begin
      st_rec <= set_rec  || (st_rec && !clr[0]);
      st_ovr <= set_drop || (st_ovr && !clr[1]);
      st_bna <= set_drop || (st_bna && !clr[2]);
    end
  end

  AST_REC_STICKY: assert property (@(posedge clk) disable iff (rst)
    set_rec |=> st_rec);  // R8
  AST_REC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr[0] && !set_rec) |=> !st_rec);  // R8
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    set_drop |=> (st_ovr && st_bna));  // R7
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BUF_BYTES = 1536,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [CLS_W-1:0] rx_class,
  input  logic             sw_wr,
  input  logic             sw_rd,
  input  logic [IW:0]      sw_addr,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic             qptr_wr,
  input  logic [IW-1:0]    qptr_idx,
  input  logic [2:0]       st_clr,
  output logic             st_rec,
  output logic             st_ovr,
  output logic             st_bna,
  output logic [IW-1:0]    cur_idx
);
  logic          hw_wr;
  logic [31:0]   hw_word1;
  logic          cur_own;
  logic          cur_wrap;
  logic          ev_rec;
  logic          ev_drop;

  rxr_ring_walk #(.DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .rx_class (rx_class),
    .qptr_wr  (qptr_wr),
    .qptr_idx (qptr_idx),
    .cur_own  (cur_own),
    .cur_wrap (cur_wrap),
    .idx      (cur_idx),
    .hw_wr    (hw_wr),
    .hw_word1 (hw_word1),
    .ev_rec   (ev_rec),
    .ev_drop  (ev_drop)
  );

  rxr_desc_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .sw_wr     (sw_wr),
    .sw_rd     (sw_rd),
    .sw_addr   (sw_addr),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .hw_wr     (hw_wr),
    .hw_idx    (cur_idx),
    .hw_word1  (hw_word1),
    .look_idx  (cur_idx),
    .look_own  (cur_own),
    .look_wrap (cur_wrap)
  );

  rxr_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_rec  (ev_rec),
    .set_drop (ev_drop),
    .clr      (st_clr),
    .st_rec   (st_rec),
    .st_ovr   (st_ovr),
    .st_bna   (st_bna)
  );
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
  localparam int DEPTH = 16;
  localparam int IW    = 4;
  localparam int CAP   = 1536;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, rx_en = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [8:0] rx_class = '0;
  logic sw_wr = 1'b0, sw_rd = 1'b0;
  logic [IW:0] sw_addr = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic qptr_wr = 1'b0;
  logic [IW-1:0] qptr_idx = '0;
  logic [2:0] st_clr = '0;
  logic st_rec, st_ovr, st_bna;
  logic [IW-1:0] cur_idx;

  rxr_ring_writer #(.DEPTH(DEPTH), .BUF_BYTES(CAP)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_class(rx_class), .sw_wr(sw_wr), .sw_rd(sw_rd),
    .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .qptr_wr(qptr_wr), .qptr_idx(qptr_idx), .st_clr(st_clr), .st_rec(st_rec),
    .st_ovr(st_ovr), .st_bna(st_bna), .cur_idx(cur_idx));

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [IW-1:0] exp_idx = '0, base_m = '0;
  bit own_m [DEPTH];
  bit wrap_m [DEPTH];

  typedef struct { logic [IW-1:0] ent; logic [31:0] w1; } exp_t;
  exp_t sb [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(logic [IW:0] a, logic [31:0] d);
    @(negedge clk); sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk); sw_wr = 1'b0;
    if (!a[0]) begin
      own_m[a[IW:1]]  = d[0];
      wrap_m[a[IW:1]] = d[1];
    end
  endtask

  task automatic sw_read(logic [IW:0] a, output logic [31:0] d);
    @(negedge clk); sw_rd = 1'b1; sw_addr = a;
    @(negedge clk); sw_rd = 1'b0; d = sw_rdata;
  endtask

  task automatic pulse_clr(logic [2:0] m);
    @(negedge clk); st_clr = m;
    @(negedge clk); st_clr = '0;
  endtask

  task automatic set_en(logic v);
    @(negedge clk); rx_en = v;
    if (!v) exp_idx = base_m;
  endtask

  task automatic load_qptr(logic [IW-1:0] v);
    @(negedge clk); qptr_wr = 1'b1; qptr_idx = v;
    @(negedge clk); qptr_wr = 1'b0;
    if (!rx_en) begin base_m = v; exp_idx = v; end
  endtask

  // driver: sends a frame and pushes the expected descriptor into the scoreboard
  task automatic send_frame(int n, logic [8:0] cls, bit clr_on_end, string req);
    bit claimed;
    logic [10:0] len;
    claimed = rx_en && !own_m[exp_idx];
    len = (n > CAP) ? 11'(CAP) : 11'(n);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (b == 0); rx_eof = (b == n - 1); rx_class = cls;
      st_clr = (clr_on_end && b == n - 1) ? 3'b001 : 3'b000;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; st_clr = '0;
    if (claimed) begin
      sb.push_back('{ent: exp_idx, w1: {cls, 12'b0, len}});
      own_m[exp_idx] = 1'b1;
      exp_idx = wrap_m[exp_idx] ? base_m
              : ((exp_idx == IW'(DEPTH - 1)) ? '0 : exp_idx + IW'(1));
    end
    check(req, 32'(cur_idx), 32'(exp_idx));
  endtask

  // monitor: pops expected descriptors and compares with what the design wrote
  task automatic drain();
    logic [31:0] d;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      sw_read({e.ent, 1'b1}, d);
      check("R2 word1", d, e.w1);
      sw_read({e.ent, 1'b0}, d);
      check("R2 ownership bit", 32'(d[0]), 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 status", {29'b0, st_rec, st_ovr, st_bna}, 32'd0);
    check("R1 index", 32'(cur_idx), 32'd0);
    sw_read({4'd9, 1'b0}, d);
    check("R1 flags", 32'(d[1:0]), 32'd0);

    for (int i = 0; i < DEPTH; i++) sw_write({IW'(i), 1'b0}, 32'h1000 * (i + 1));
    sw_read({4'd5, 1'b0}, d);
    check("R5 readback", d, 32'h6000);

    load_qptr('0);
    set_en(1'b1);
    @(negedge clk);
    check("R9 start at base", 32'(cur_idx), 32'd0);

    send_frame(64, 9'h100, 1'b0, "R2 broadcast frame");
    send_frame(1, 9'h001, 1'b0, "R3 single beat");
    send_frame(1600, 9'h0A0, 1'b0, "R3 truncation");
    check("R8 received set", 32'(st_rec), 32'd1);
    drain();

    pulse_clr(3'b001);
    check("R8 clear", 32'(st_rec), 32'd0);
    send_frame(2, 9'h040, 1'b1, "R4 advance");
    check("R8 set beats clear", 32'(st_rec), 32'd1);
    pulse_clr(3'b001);
    check("R8 clear again", 32'(st_rec), 32'd0);
    drain();

    sw_write({4'd0, 1'b1}, 32'h0);
    sw_read({4'd0, 1'b1}, d);
    check("R6 word1 write ignored", d, {9'h100, 12'b0, 11'd64});

    pulse_clr(3'b111);
    sw_write({exp_idx, 1'b0}, 32'h5001);
    send_frame(20, 9'h010, 1'b0, "R7 index held");
    check("R7 flags", {29'b0, st_rec, st_ovr, st_bna}, 32'b011);
    sw_read({4'd4, 1'b0}, d);
    check("R7 descriptor untouched", d, 32'h5001);

    sw_write({4'd4, 1'b0}, 32'h5002);
    sw_read({4'd4, 1'b0}, d);
    check("R5 wrap bit", d, 32'h5002);
    send_frame(30, 9'h008, 1'b0, "R4 wrap to base");
    drain();

    set_en(1'b0);
    load_qptr(4'd15);
    set_en(1'b1);
    @(negedge clk);
    check("R10 base load", 32'(cur_idx), 32'd15);
    send_frame(8, 9'h002, 1'b0, "R4 end of ring");
    drain();

    load_qptr(4'd7);
    check("R10 ignored while enabled", 32'(cur_idx), 32'(exp_idx));
    set_en(1'b0);
    repeat (2) @(negedge clk);
    check("R10 base kept", 32'(cur_idx), 32'd15);

    pulse_clr(3'b111);
    send_frame(10, 9'h004, 1'b0, "R9 disabled index");
    check("R9 disabled no status", {29'b0, st_rec, st_ovr, st_bna}, 32'd0);

    sw_write({4'd15, 1'b0}, 32'h10000);
    set_en(1'b1);
    for (int b = 0; b < 5; b++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = (b == 0); rx_eof = 1'b0;
    end
    @(negedge clk); rx_en = 1'b0; rx_eof = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    @(negedge clk);
    check("R9 abort no status", 32'(st_rec), 32'd0);
    check("R9 abort index", 32'(cur_idx), 32'd15);
    sw_read({4'd15, 1'b0}, d);
    check("R9 abort descriptor", d, 32'h10000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule